// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block guesses the direction of a conditional branch while it is still being fetched. The fetch side presents a program counter. In the same cycle, with no register in the path, the block returns a taken or not-taken guess. It also returns the global history value that produced the guess, so the fetch pipeline can carry that value along with the branch.

The storage is a set of tables of two-bit saturating-with-hysteresis counters. There is one table for every value of a short global history register, and each table is indexed by PC bits above the instruction-alignment bits. The history register records the outcomes of the most recently resolved branches.

When a branch resolves in execute, the resolve side presents the branch PC, the real outcome and the history value carried from prediction time. The block then updates the counter that made the guess and shifts the outcome into the global history. A counter reverses its guess only after two wrong guesses in a row. The tables are held in flops, so a prediction and an update can touch the same counter in the same cycle, and in that case the prediction sees the value from before the update.

Top module: `corr_bp`

## Requirements
- R1: After reset every counter holds 01, so every guess is not-taken, and the global history reads 00 on `pred_hist`.
- R2: `pred_taken` is bit 1 of the counter selected by the current history and by `fetch_pc[ALIGN_W+IDX_W-1:ALIGN_W]`. It follows `fetch_pc` in the same cycle.
- R3: On a not-taken outcome, a counter at 11 moves to 10 (still guessing taken) and a counter at 10 moves to 00. On a taken outcome, 10 returns to 11 and 11 stays at 11.
- R4: An update writes only the counter table chosen by `upd_hist`, whatever the current history is. Each history value owns a separate set of counters.
- R5: Each valid update shifts the history left by one, and the outcome enters at bit 0 (1 = taken).
- R6: A counter that starts at 11 keeps guessing taken after one not-taken outcome. It guesses not-taken only after a second consecutive not-taken outcome.
- R7: On a taken outcome, 00 moves to 01 and 01 moves to 11. On a not-taken outcome, 01 moves to 00 and 00 stays at 00.
- R8: If a prediction and an update address the same counter in one cycle, the prediction returns the counter value from before the update.
- R9: PC bits below `ALIGN_W` and above `ALIGN_W+IDX_W` take no part in the choice of counter, so such PCs share one counter.
- R10: While `upd_valid` is low, the resolve inputs change neither any counter nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_taken | output | 1 | Direction guess for `fetch_pc` |
| pred_hist | output | HIST_W | History value used for this guess |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W | History value carried from prediction time |

## Verification
The bench drives one counter through every hysteresis path and reads its state through the guess alone. A design that flipped after a single miss, or that skipped the weak states, would show a wrong guess in the middle of these sequences. It trains one PC under a single history value while the live history differs, then checks the other three sets. A design that indexed updates by the live history would have trained the wrong set. It also collides a guess with an update on the same counter, where a bypassing design would return the new value early. Finally, it probes aliased PCs and idle resolve inputs, which catch extra index bits and updates that are not gated by `upd_valid`.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

   typedef enum logic [1:0] {
      CTR_NT_OK   = 2'b00,
      CTR_NT_MISS = 2'b01,
      CTR_T_MISS  = 2'b10,
      CTR_T_OK    = 2'b11
   } ctr_e;

   localparam ctr_e CTR_INIT = CTR_NT_MISS;

   // hysteresis step: a guess reverses only after two misses in a row
   function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
      ctr_e nxt;
      case (cur)
         CTR_T_OK:    nxt = taken ? CTR_T_OK    : CTR_T_MISS;
         CTR_T_MISS:  nxt = taken ? CTR_T_OK    : CTR_NT_OK;
         CTR_NT_MISS: nxt = taken ? CTR_T_OK    : CTR_NT_OK;
         default:     nxt = taken ? CTR_NT_MISS : CTR_NT_OK;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/corr_bp_ghr.sv
module corr_bp_ghr #(
   parameter int HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] hist_nxt;

   generate
      if (HIST_W == 1) begin : g_one
         assign hist_nxt = shift_bit;
      end else begin : g_many
         assign hist_nxt = {hist[HIST_W-2:0], shift_bit};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= hist_nxt;
   end

   assert_shift_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(shift_bit));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));

endmodule

// File: rtl/corr_bp_bank.sv
module corr_bp_bank
   import corr_bp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_e             rd_state,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;

   ctr_e tbl [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_INIT;
      end else if (wr_en) begin
         tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
      end
   end

   // read is combinational from the flops: same-cycle write is not bypassed (R8)
   assign rd_state = tbl[rd_idx];

   assert_taken_leaves_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken) |=> tbl[$past(wr_idx)] != CTR_NT_OK);

   assert_nt_leaves_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken) |=> tbl[$past(wr_idx)] != CTR_T_OK);

   assert_no_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> tbl[$past(rd_idx)] == $past(rd_state));

endmodule

// File: rtl/corr_bp_sel.sv
module corr_bp_sel
   import corr_bp_pkg::*;
#(
   parameter int HIST_W = 2,
   parameter int NSETS  = 4
) (
   input  ctr_e              set_state [NSETS],
   input  logic [HIST_W-1:0] sel,
   output logic              taken
);
   logic [1:0] picked;

   always_comb begin
      picked = set_state[sel];
      taken  = picked[1];
   end

endmodule

// File: rtl/corr_bp.sv
module corr_bp
   import corr_bp_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 8,
   parameter int ALIGN_W = 2,
   parameter int HIST_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   fetch_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [HIST_W-1:0] upd_hist
);
   localparam int NSETS = 1 << HIST_W;
   localparam int IDX_LO = ALIGN_W;
   localparam int IDX_HI = ALIGN_W + IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 14) begin : g_bad_idx
         $error("corr_bp: IDX_W out of range");
      end
      if (ALIGN_W < 1 || IDX_HI >= PC_W) begin : g_bad_align
         $error("corr_bp: index field does not fit inside PC");
      end
      if (HIST_W < 1 || HIST_W > 4) begin : g_bad_hist
         $error("corr_bp: HIST_W out of range");
      end
   endgenerate

   logic [IDX_W-1:0] fetch_idx, upd_idx;
   logic [HIST_W-1:0] ghr;
   logic [NSETS-1:0] set_we;
   ctr_e set_state [NSETS];
   logic unused_pc_bits;

   assign fetch_idx = fetch_pc[IDX_HI-1:IDX_LO];
   assign upd_idx   = upd_pc[IDX_HI-1:IDX_LO];
   assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI], fetch_pc[IDX_LO-1:0],
                             upd_pc[PC_W-1:IDX_HI], upd_pc[IDX_LO-1:0]};

   corr_bp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_bit (upd_taken),
      .hist      (ghr)
   );

   generate
      for (genvar s = 0; s < NSETS; s++) begin : g_set
         assign set_we[s] = upd_valid && (upd_hist == HIST_W'(s));
         corr_bp_bank #(.IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (fetch_idx),
            .rd_state (set_state[s]),
            .wr_en    (set_we[s]),
            .wr_idx   (upd_idx),
            .wr_taken (upd_taken)
         );
      end
   endgenerate

   corr_bp_sel #(.HIST_W(HIST_W), .NSETS(NSETS)) u_sel (
      .set_state (set_state),
      .sel       (ghr),
      .taken     (pred_taken)
   );

   assign pred_hist = ghr;

   assert_one_set_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_we));

   assert_set_follows_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $countones(set_we) == 1);

endmodule

// File: tb/corr_bp_bench.sv
module corr_bp_bench;
   localparam int PC_W = 32;
   localparam int HW   = 2;

   localparam logic [31:0] PC_A    = 32'h0000_0104;
   localparam logic [31:0] PC_B    = 32'h0000_0208;
   localparam logic [31:0] PC_C    = 32'h0000_0310;
   localparam logic [31:0] PC_JUNK = 32'h0000_03FC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic pred_taken;
   logic [HW-1:0] pred_hist;
   logic upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic upd_taken = 1'b0;
   logic [HW-1:0] upd_hist = '0;

   int n_chk = 0;
   int n_fail = 0;
   logic [HW-1:0] g = '0;

   always #4 clk = ~clk;

   corr_bp u_corr_bp (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_hist(upd_hist)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic resolve(input logic [31:0] pc, input logic t, input logic [HW-1:0] h);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
      @(posedge clk);
      g = {g[0], t};
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // steer the live history to h using a counter nobody reads
   task automatic set_ghr(input logic [HW-1:0] h);
      resolve(PC_JUNK, h[1], 2'b00);
      resolve(PC_JUNK, h[0], 2'b00);
   endtask

   task automatic guess_is(input logic [31:0] pc, input logic [HW-1:0] h,
                           input logic exp, input string tag);
      set_ghr(h);
      fetch_pc = pc;
      #1;
      check(tag, {31'd0, pred_taken}, {31'd0, exp});
      check({tag, " hist"}, {30'd0, pred_hist}, {30'd0, h});
   endtask

   task automatic t_reset;
      fetch_pc = PC_A; #1;
      check("R1 guess A", {31'd0, pred_taken}, 32'd0);
      check("R1 hist", {30'd0, pred_hist}, 32'd0);
      fetch_pc = PC_B; #1;
      check("R1 guess B", {31'd0, pred_taken}, 32'd0);
   endtask

   task automatic t_hysteresis;
      resolve(PC_A, 1'b1, 2'b00);            // 01 -> 11
      guess_is(PC_A, 2'b00, 1'b1, "R7 01 on T");
      resolve(PC_A, 1'b0, 2'b00);            // 11 -> 10
      guess_is(PC_A, 2'b00, 1'b1, "R6 one miss keeps T");
      resolve(PC_A, 1'b1, 2'b00);            // 10 -> 11
      guess_is(PC_A, 2'b00, 1'b1, "R3 10 on T");
      resolve(PC_A, 1'b0, 2'b00);            // 11 -> 10
      resolve(PC_A, 1'b0, 2'b00);            // 10 -> 00
      guess_is(PC_A, 2'b00, 1'b0, "R3 two misses flip");
      resolve(PC_A, 1'b1, 2'b00);            // 00 -> 01
      guess_is(PC_A, 2'b00, 1'b0, "R7 00 on T still NT");
      resolve(PC_A, 1'b0, 2'b00);            // 01 -> 00
      resolve(PC_A, 1'b1, 2'b00);            // 00 -> 01
      resolve(PC_A, 1'b1, 2'b00);            // 01 -> 11
      guess_is(PC_A, 2'b00, 1'b1, "R7 00 T T reaches 11");
      resolve(PC_A, 1'b0, 2'b00);            // 11 -> 10
      resolve(PC_A, 1'b0, 2'b00);            // 10 -> 00
      resolve(PC_A, 1'b0, 2'b00);            // 00 stays
      resolve(PC_A, 1'b1, 2'b00);            // 00 -> 01
      guess_is(PC_A, 2'b00, 1'b0, "R7 00 holds on NT");
   endtask

   task automatic t_sets;
      set_ghr(2'b01);
      resolve(PC_B, 1'b1, 2'b10);
      resolve(PC_B, 1'b1, 2'b10);
      guess_is(PC_B, 2'b10, 1'b1, "R4 trained set");
      guess_is(PC_B, 2'b00, 1'b0, "R4 set 00 untouched");
      guess_is(PC_B, 2'b01, 1'b0, "R4 set 01 untouched");
      guess_is(PC_B, 2'b11, 1'b0, "R4 set 11 untouched");
   endtask

   task automatic t_history;
      set_ghr(2'b00);
      resolve(PC_JUNK, 1'b1, 2'b00);
      #1 check("R5 shift 1", {30'd0, pred_hist}, 32'd1);
      resolve(PC_JUNK, 1'b0, 2'b00);
      #1 check("R5 shift 2", {30'd0, pred_hist}, 32'd2);
      resolve(PC_JUNK, 1'b1, 2'b00);
      #1 check("R5 shift 3", {30'd0, pred_hist}, 32'd1);
      resolve(PC_JUNK, 1'b1, 2'b00);
      #1 check("R5 shift 4", {30'd0, pred_hist}, 32'd3);
   endtask

   task automatic t_alias;
      guess_is(PC_B | 32'h3, 2'b10, 1'b1, "R9 low bits ignored");
      guess_is(PC_B + 32'h400, 2'b10, 1'b1, "R9 high bits ignored");
      guess_is(PC_B + 32'h4, 2'b10, 1'b0, "R2 next index differs");
   endtask

   task automatic t_collide;
      set_ghr(2'b00);
      @(negedge clk);
      fetch_pc = PC_C;
      upd_valid = 1'b1; upd_pc = PC_C; upd_taken = 1'b1; upd_hist = 2'b00;
      #1 check("R8 old value same cycle", {31'd0, pred_taken}, 32'd0);
      @(posedge clk);
      g = {g[0], 1'b1};
      @(negedge clk);
      upd_valid = 1'b0;
      guess_is(PC_C, 2'b00, 1'b1, "R8 new value after edge");
   endtask

   task automatic t_idle;
      set_ghr(2'b00);
      upd_valid = 1'b0; upd_pc = PC_C; upd_taken = 1'b0; upd_hist = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      fetch_pc = PC_C; #1;
      check("R10 hist held", {30'd0, pred_hist}, 32'd0);
      check("R10 counter held", {31'd0, pred_taken}, 32'd1);
      upd_taken = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      resolve(PC_C, 1'b0, 2'b00);             // 11 -> 10 proves counter was 11
      guess_is(PC_C, 2'b00, 1'b1, "R10 counter state intact");
   endtask

   initial begin
      #(8 * 100000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hysteresis();
      t_sets();
      t_history();
      t_alias();
      t_collide();
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule